// File: doc/BRIEF.md
# ADC Step Sequencer with Result FIFO

This block runs a short, programmed list of analog conversion steps. A 16-bit control word describes up to four steps, one nibble each. On a trigger, the sequencer works through the steps in order. For each step it sends one request to an external converter and waits for the result, which comes back over a request/done handshake. Each returned result is written into a four-entry result FIFO. A step may raise a one-cycle interrupt pulse of its own.

Software drains the FIFO through a read strobe. It sees a packed status word with the read and write pointers and the empty and full bits. Two sticky error flags record a write into a full FIFO and a read from an empty one. Each flag clears only when a 1 is strobed on its clear input. The analog converter is outside the block.

Top module: `adcseq_top`

## Requirements
- R1: Step n of `ctl_word` sits in bits [4n+3:4n]. Within a step, bit 3 selects the temperature sensor, bit 2 enables the step interrupt, bit 1 marks the last step and bit 0 selects differential input. Each request presents that step's bit 3 on `conv_temp`, its bit 0 on `conv_diff`, and n on `conv_chan`.
- R2: A `trig` seen while idle makes `busy` high and `conv_req` high for exactly one cycle in the next cycle, with `conv_chan` = 0.
- R3: Steps are requested in ascending order, and each request follows, one cycle later, the `conv_done` of the step before it. The sequence ends with the first step whose last-step bit is set. `busy` falls in the cycle after that step's `conv_done`.
- R4: If no step has its last-step bit set, the sequence runs all four steps and ends after step 3.
- R5: A `trig` while `busy` is high is ignored: it issues no extra request and does not restart the sequence.
- R6: Results are read out in the order they were converted. `rd_data` takes the oldest entry one cycle after an `rd_en` on a non-empty FIFO. A result enters the FIFO one cycle after its `conv_done`.
- R7: `status` packs the read pointer in [3:0], the write pointer in [7:4], empty in bit 8 and full in bit 12. All other bits are 0. After reset `status` is 16'h0100.
- R8: A result that arrives while the FIFO is full, with no read in the same cycle, is dropped and sets `ovf_flag`. The flag stays set until `ovf_clr` is 1.
- R9: An `rd_en` on an empty FIFO sets `unf_flag` and leaves `rd_data` and the pointers unchanged. The flag stays set until `unf_clr` is 1.
- R10: When a step with its interrupt bit set completes, `step_irq[n]` is high for one cycle, in the cycle after that step's `conv_done`. At most one bit is ever high.
- R11: A read and a write in the same cycle on a full FIFO both take effect. No overflow is recorded, and the FIFO stays full with both pointers advanced.
- R12: A `conv_done` while idle is ignored: it issues no request, no interrupt and no FIFO write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_word | input | 16 | Step configuration, one nibble per step |
| trig | input | 1 | Sequence start |
| conv_req | output | 1 | One-cycle conversion request |
| conv_temp | output | 1 | Request: temperature sensor select |
| conv_diff | output | 1 | Request: differential input |
| conv_chan | output | 2 | Request: input channel (step number) |
| conv_done | input | 1 | Converter result valid |
| conv_data | input | 10 | Converter result |
| busy | output | 1 | Sequence in progress |
| step_irq | output | 4 | Per-step interrupt pulses |
| rd_en | input | 1 | FIFO read strobe |
| rd_data | output | 10 | Oldest result, registered |
| status | output | 16 | Pointers, empty and full |
| ovf_flag | output | 1 | Sticky overflow |
| unf_flag | output | 1 | Sticky underflow |
| ovf_clr | input | 1 | Clear overflow when 1 |
| unf_clr | input | 1 | Clear underflow when 1 |

## Verification
A FIFO write caused by a returning result can land in the same cycle as a software read. The case that matters is a full FIFO, where both operations hit the same memory slot. The bench fills the FIFO and then starts a one-step sequence with a hand-driven converter. It raises `rd_en` in the cycle after `conv_done`, which is exactly when the write takes effect. The run is judged by the oldest value coming out, no overflow being flagged, the status staying full with both pointers moved, and the new result leaving last.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  // One step nibble, most significant field first.
  typedef struct packed {
    logic temp;
    logic irq_en;
    logic last;
    logic diff;
  } step_cfg_t;

  typedef enum logic {ST_IDLE, ST_WAIT} seq_state_t;
endpackage

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int STEPS = 4,
  parameter int RES_W = 10,
  localparam int CH_W = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [4*STEPS-1:0] cfg,
  input  logic               trig,
  input  logic               conv_done,
  input  logic [RES_W-1:0]   conv_data,
  output logic               conv_req,
  output logic               conv_temp,
  output logic               conv_diff,
  output logic [CH_W-1:0]    conv_chan,
  output logic               busy,
  output logic               wr_en,
  output logic [RES_W-1:0]   wr_data,
  output logic [STEPS-1:0]   step_irq
);
  localparam logic [CH_W-1:0] LAST_IDX = CH_W'(STEPS - 1);
  localparam logic [CH_W-1:0] IDX_ONE  = CH_W'(1);
  localparam logic [STEPS-1:0] IRQ_ONE = STEPS'(1);

  step_cfg_t        steps [STEPS];
  seq_state_t       state;
  logic [CH_W-1:0]  idx;
  logic [CH_W-1:0]  nxt;
  step_cfg_t        cur;
  logic             is_last;

  for (genvar g = 0; g < STEPS; g++) begin : g_unpack
    assign steps[g] = step_cfg_t'(cfg[4*g +: 4]);
  end

  assign cur     = steps[idx];
  assign nxt     = idx + IDX_ONE;
  assign is_last = cur.last || (idx == LAST_IDX);
  assign busy    = (state == ST_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      idx       <= '0;
      conv_req  <= 1'b0;
      conv_temp <= 1'b0;
      conv_diff <= 1'b0;
      conv_chan <= '0;
      wr_en     <= 1'b0;
      wr_data   <= '0;
      step_irq  <= '0;
    end else begin
      conv_req <= 1'b0;
      wr_en    <= 1'b0;
      step_irq <= '0;
      unique case (state)
        ST_IDLE: begin
          if (trig) begin
            state     <= ST_WAIT;
            idx       <= '0;
            conv_req  <= 1'b1;
            conv_temp <= steps[0].temp;
            conv_diff <= steps[0].diff;
            conv_chan <= '0;
          end
        end
        ST_WAIT: begin
          if (conv_done) begin
            wr_en   <= 1'b1;
            wr_data <= conv_data;
            if (cur.irq_en) step_irq <= IRQ_ONE << idx;
            if (is_last) begin
              state <= ST_IDLE;
            end else begin
              idx       <= nxt;
              conv_req  <= 1'b1;
              conv_temp <= steps[nxt].temp;
              conv_diff <= steps[nxt].diff;
              conv_chan <= nxt;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/adcseq_fifo.sv
module adcseq_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic [AW-1:0] head,
  output logic [AW-1:0] tail,
  output logic          empty,
  output logic          full,
  output logic          ovf_evt,
  output logic          unf_evt
);
  localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW:0]   CNT_ONE  = (AW+1)'(1);
  localparam logic [AW-1:0] PTR_TOP  = AW'(DEPTH - 1);
  localparam logic [AW-1:0] PTR_ONE  = AW'(1);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  cnt;
  logic         do_rd;
  logic         do_wr;

  assign empty   = (cnt == '0);
  assign full    = (cnt == FULL_CNT);
  assign do_rd   = rd_en && !empty;
  assign do_wr   = wr_en && (!full || do_rd);
  assign ovf_evt = wr_en && !do_wr;
  assign unf_evt = rd_en && empty;

  // Memory array without reset so it maps to block RAM.
  always_ff @(posedge clk) begin
    if (do_wr) mem[head] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (do_rd) rd_data <= mem[tail];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else begin
      if (do_wr) head <= (head == PTR_TOP) ? '0 : head + PTR_ONE;
      if (do_rd) tail <= (tail == PTR_TOP) ? '0 : tail + PTR_ONE;
      unique case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + CNT_ONE;
        2'b01:   cnt <= cnt - CNT_ONE;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/adcseq_flags.sv
module adcseq_flags #(
  parameter int NFLAG = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] evt,
  input  logic [NFLAG-1:0] clr,
  output logic [NFLAG-1:0] flag
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_sticky
    always_ff @(posedge clk) begin
      if (rst)         flag[i] <= 1'b0;
      else if (evt[i]) flag[i] <= 1'b1;
      else if (clr[i]) flag[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/adcseq_top.sv
module adcseq_top #(
  parameter int STEPS = 4,
  parameter int RES_W = 10,
  parameter int DEPTH = 4,
  parameter int CH_W  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [4*STEPS-1:0] ctl_word,
  input  logic               trig,
  output logic               conv_req,
  output logic               conv_temp,
  output logic               conv_diff,
  output logic [CH_W-1:0]    conv_chan,
  input  logic               conv_done,
  input  logic [RES_W-1:0]   conv_data,
  output logic               busy,
  output logic [STEPS-1:0]   step_irq,
  input  logic               rd_en,
  output logic [RES_W-1:0]   rd_data,
  output logic [15:0]        status,
  output logic               ovf_flag,
  output logic               unf_flag,
  input  logic               ovf_clr,
  input  logic               unf_clr
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = 4;

  logic             wr_en;
  logic [RES_W-1:0] wr_data;
  logic [AW-1:0]    head;
  logic [AW-1:0]    tail;
  logic             empty;
  logic             full;
  logic             ovf_evt;
  logic             unf_evt;
  logic [1:0]       flags;

  adcseq_ctrl #(.STEPS(STEPS), .RES_W(RES_W)) u_ctrl (
    .clk(clk), .rst(rst), .cfg(ctl_word), .trig(trig),
    .conv_done(conv_done), .conv_data(conv_data),
    .conv_req(conv_req), .conv_temp(conv_temp), .conv_diff(conv_diff),
    .conv_chan(conv_chan), .busy(busy), .wr_en(wr_en), .wr_data(wr_data),
    .step_irq(step_irq)
  );

  adcseq_fifo #(.W(RES_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .head(head), .tail(tail), .empty(empty), .full(full),
    .ovf_evt(ovf_evt), .unf_evt(unf_evt)
  );

  adcseq_flags #(.NFLAG(2)) u_flags (
    .clk(clk), .rst(rst),
    .evt({unf_evt, ovf_evt}), .clr({unf_clr, ovf_clr}), .flag(flags)
  );

  assign ovf_flag = flags[0];
  assign unf_flag = flags[1];
  assign status   = {3'b000, full, 3'b000, empty,
                     {(PW-AW){1'b0}}, head, {(PW-AW){1'b0}}, tail};
endmodule

// File: rtl/adcseq_chk.sv
module adcseq_chk #(
  parameter int STEPS = 4,
  parameter int RES_W = 10,
  parameter int CH_W  = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             trig,
  input logic             busy,
  input logic             conv_req,
  input logic [CH_W-1:0]  conv_chan,
  input logic             conv_done,
  input logic [STEPS-1:0] step_irq,
  input logic             rd_en,
  input logic [RES_W-1:0] rd_data,
  input logic [15:0]      status,
  input logic             ovf_flag,
  input logic             ovf_clr,
  input logic             unf_flag,
  input logic             unf_clr
);
  assert_trig_start_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && trig) |=> (busy && conv_req && conv_chan == '0));

  assert_req_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    conv_req |=> !conv_req);

  assert_req_busy_R3: assert property (@(posedge clk) disable iff (rst)
    conv_req |-> busy);

  assert_trig_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && trig && !conv_done) |=> !conv_req);

  assert_full_empty_R7: assert property (@(posedge clk) disable iff (rst)
    !(status[8] && status[12]));

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  assert_unf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (unf_flag && !unf_clr) |=> unf_flag);

  assert_unf_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && status[8]) |=> (unf_flag && $stable(rd_data)));

  assert_irq_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(step_irq));

  assert_idle_done_R12: assert property (@(posedge clk) disable iff (rst)
    (!busy && conv_done && !trig) |=> (step_irq == '0 && !conv_req));
endmodule

bind adcseq_top adcseq_chk #(.STEPS(STEPS), .RES_W(RES_W), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst(rst), .trig(trig), .busy(busy), .conv_req(conv_req),
  .conv_chan(conv_chan), .conv_done(conv_done), .step_irq(step_irq),
  .rd_en(rd_en), .rd_data(rd_data), .status(status),
  .ovf_flag(ovf_flag), .ovf_clr(ovf_clr), .unf_flag(unf_flag), .unf_clr(unf_clr)
);

// File: tb/adcseq_top_test.sv
module adcseq_top_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic [15:0] ctl_word = '0;
  logic        trig = 1'b0, rd_en = 1'b0, ovf_clr = 1'b0, unf_clr = 1'b0;
  logic        auto_done = 1'b0, man_done = 1'b0;
  logic [9:0]  auto_data = '0, man_data = '0;
  wire         conv_done = auto_done | man_done;
  wire  [9:0]  conv_data = man_done ? man_data : auto_data;
  logic        conv_req, conv_temp, conv_diff, busy, ovf_flag, unf_flag;
  logic [1:0]  conv_chan;
  logic [3:0]  step_irq;
  logic [9:0]  rd_data;
  logic [15:0] status;

  adcseq_top uut (
    .clk(clk), .rst(rst), .ctl_word(ctl_word), .trig(trig),
    .conv_req(conv_req), .conv_temp(conv_temp), .conv_diff(conv_diff),
    .conv_chan(conv_chan), .conv_done(conv_done), .conv_data(conv_data),
    .busy(busy), .step_irq(step_irq), .rd_en(rd_en), .rd_data(rd_data),
    .status(status), .ovf_flag(ovf_flag), .unf_flag(unf_flag),
    .ovf_clr(ovf_clr), .unf_clr(unf_clr)
  );

  int checks = 0, fails = 0;
  int req_n = 0, irq_n = 0, resp_n = 0, pend = 0;
  bit auto_on = 1'b1;
  logic [1:0] req_chan [16];
  logic       req_temp [16];
  logic       req_diff [16];
  logic [3:0] irq_log  [16];

  // Converter model: answers each request two cycles later; logs requests and interrupts.
  always @(negedge clk) begin
    auto_done <= 1'b0;
    if (pend > 0) begin
      pend = pend - 1;
      if (pend == 0) begin
        auto_done <= 1'b1;
        auto_data <= 10'(10'h3A0 + resp_n);
        resp_n++;
      end
    end
    if (conv_req) begin
      if (req_n < 16) begin
        req_chan[req_n] = conv_chan;
        req_temp[req_n] = conv_temp;
        req_diff[req_n] = conv_diff;
      end
      req_n++;
      if (auto_on) pend = 2;
    end
    if (step_irq != 4'b0) begin
      if (irq_n < 16) irq_log[irq_n] = step_irq;
      irq_n++;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start(logic [15:0] cfg);
    ctl_word = cfg;
    req_n = 0;
    irq_n = 0;
    trig = 1'b1;
    tick(1);
    trig = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 200) begin tick(1); t++; end
    chk("R3 sequence finishes", 32'(busy), 32'd0);
    tick(2);
  endtask

  task automatic read_one(output logic [9:0] d);
    rd_en = 1'b1;
    tick(1);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    tick(1);
    chk("R7 reset status", 32'(status), 32'h0100);
    chk("R2 reset busy", 32'(busy), 0);
    chk("R2 reset req", 32'(conv_req), 0);
    chk("R8 reset ovf", 32'(ovf_flag), 0);
    chk("R9 reset unf", 32'(unf_flag), 0);
  endtask

  task automatic t_full_seq();
    int base = resp_n;
    logic [9:0] d;
    start(16'h6841);
    chk("R2 busy after trigger", 32'(busy), 1);
    wait_idle();
    chk("R3 four requests", 32'(req_n), 4);
    for (int k = 0; k < 4; k++) begin
      chk("R1 channel", 32'(req_chan[k]), 32'(k));
      chk("R1 temp bit", 32'(req_temp[k]), 32'(k == 2));
      chk("R1 diff bit", 32'(req_diff[k]), 32'(k == 0));
    end
    chk("R10 irq count", 32'(irq_n), 2);
    chk("R10 irq step1", 32'(irq_log[0]), 32'h2);
    chk("R10 irq step3", 32'(irq_log[1]), 32'h8);
    chk("R7 full status", 32'(status), 32'h1000);
    read_one(d);
    chk("R6 first result", 32'(d), 32'(10'h3A0 + base));
    chk("R7 status after read", 32'(status), 32'h0001);
    for (int k = 1; k < 4; k++) begin
      read_one(d);
      chk("R6 result order", 32'(d), 32'(10'h3A0 + base + k));
    end
    chk("R7 empty status", 32'(status), 32'h0100);
  endtask

  task automatic t_end_first();
    logic [9:0] d;
    start(16'h0002);
    wait_idle();
    chk("R3 end at step 0", 32'(req_n), 1);
    chk("R7 one entry", 32'(status), 32'h0010);
    read_one(d);
    chk("R7 drained", 32'(status), 32'h0111);
  endtask

  task automatic t_end_mid();
    int base = resp_n;
    logic [9:0] d;
    start(16'h2020);
    wait_idle();
    chk("R3 end at step 1", 32'(req_n), 2);
    chk("R3 second chan", 32'(req_chan[1]), 1);
    chk("R7 two entries", 32'(status), 32'h0031);
    read_one(d);
    chk("R6 mid first", 32'(d), 32'(10'h3A0 + base));
    read_one(d);
    chk("R6 mid second", 32'(d), 32'(10'h3A0 + base + 1));
    chk("R7 drained mid", 32'(status), 32'h0133);
  endtask

  int t4_base;
  task automatic t_no_end();
    t4_base = resp_n;
    start(16'h0000);
    wait_idle();
    chk("R4 four steps without end", 32'(req_n), 4);
    chk("R4 last chan", 32'(req_chan[3]), 3);
    chk("R10 no irq", 32'(irq_n), 0);
    chk("R7 full again", 32'(status), 32'h1033);
  endtask

  task automatic t_overflow();
    start(16'h0002);
    wait_idle();
    chk("R8 ovf set", 32'(ovf_flag), 1);
    chk("R8 status unchanged", 32'(status), 32'h1033);
    tick(3);
    chk("R8 ovf sticky", 32'(ovf_flag), 1);
    ovf_clr = 1'b1;
    tick(1);
    ovf_clr = 1'b0;
    chk("R8 ovf cleared", 32'(ovf_flag), 0);
  endtask

  task automatic t_same_cycle();
    logic [9:0] d;
    auto_on = 1'b0;
    start(16'h0002);
    tick(1);
    man_data = 10'h155;
    man_done = 1'b1;
    tick(1);
    man_done = 1'b0;
    rd_en = 1'b1;
    tick(1);
    rd_en = 1'b0;
    d = rd_data;
    chk("R11 oldest out", 32'(d), 32'(10'h3A0 + t4_base));
    chk("R11 no overflow", 32'(ovf_flag), 0);
    chk("R11 still full", 32'(status), 32'h1000);
    for (int k = 1; k < 4; k++) begin
      read_one(d);
      chk("R11 order kept", 32'(d), 32'(10'h3A0 + t4_base + k));
    end
    read_one(d);
    chk("R11 new result last", 32'(d), 32'h155);
    chk("R11 empty after", 32'(status), 32'h0100);
    auto_on = 1'b1;
  endtask

  task automatic t_underflow();
    logic [9:0] d;
    read_one(d);
    chk("R9 rd_data held", 32'(d), 32'h155);
    chk("R9 unf set", 32'(unf_flag), 1);
    chk("R9 pointers held", 32'(status), 32'h0100);
    tick(3);
    chk("R9 unf sticky", 32'(unf_flag), 1);
    unf_clr = 1'b1;
    tick(1);
    unf_clr = 1'b0;
    chk("R9 unf cleared", 32'(unf_flag), 0);
  endtask

  task automatic t_trig_busy();
    logic [9:0] d;
    start(16'h0020);
    trig = 1'b1;
    tick(1);
    trig = 1'b0;
    wait_idle();
    chk("R5 no extra request", 32'(req_n), 2);
    tick(5);
    chk("R5 stays idle", 32'(busy), 0);
    chk("R5 count unchanged", 32'(req_n), 2);
    chk("R5 two entries", 32'(status), 32'h0020);
    read_one(d);
    read_one(d);
  endtask

  task automatic t_stray_done();
    req_n = 0;
    irq_n = 0;
    ctl_word = 16'h0004;
    man_data = 10'h2AA;
    man_done = 1'b1;
    tick(1);
    man_done = 1'b0;
    tick(3);
    chk("R12 no write", 32'(status), 32'h0122);
    chk("R12 no request", 32'(req_n), 0);
    chk("R12 no irq", 32'(irq_n), 0);
  endtask

  task automatic t_irq_first();
    logic [9:0] d;
    start(16'h0006);
    wait_idle();
    chk("R10 single irq", 32'(irq_n), 1);
    chk("R10 step0 bit", 32'(irq_log[0]), 32'h1);
    read_one(d);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    tick(1);
    t_reset();
    t_full_seq();
    t_end_first();
    t_end_mid();
    t_no_end();
    t_overflow();
    t_same_cycle();
    t_underflow();
    t_trig_busy();
    t_stray_done();
    t_irq_first();
    summary();
    $finish;
  end
endmodule